// File: doc/BRIEF.md
# Start-Up Window and Security Latch Controller

This block guards a processor's debug port and its serial programming port around reset. From the moment reset is released it counts processor clock cycles through a fixed start-up window. While the window is open the debug port is held off and a read-only status flag shows that the window is active. Boot code that runs in this window can arm a sticky security latch through a register write.

Once armed, the latch can only be released by a reset. When it is set, the debug port is reduced to whole-array erase requests, and read requests from the serial port are refused. A whole-array erase completion is recorded in a sticky status flag. That flag does not clear the latch: the latch clears only when the chip is reset afterwards. The debug protocol and the flash array itself are outside this block. The block only produces one allow signal per request port.

Top module: `bootSecurityCtl`

## Requirements
- R1: After reset is released, `preBoot` (also `statusReg` bit 7) is high for exactly `PREBOOT_CYCLES` (default 64) clock cycles and then goes low.
- R2: While `preBoot` is high, `dbgAllow` is low for every debug request kind.
- R3: With `preBoot` low and `secure` low, `dbgAllow` equals `dbgReqValid` for every request kind.
- R4: Reset clears `secure`. A cycle with `regWrEn` high and `regWrData` bit 6 set makes `secure` high from the next cycle on. This works both inside and after the start-up window.
- R5: A register write can never clear `secure`. Bit 7 of `regWrData` has no effect on `statusReg` bit 7.
- R6: While `secure` is high, `dbgAllow` is high only for a valid request of kind 3 (whole-array erase). Kinds 0 (read), 1 (write) and 2 (page erase) are refused.
- R7: `spiAllow` does not depend on the start-up window. While `secure` is high, a valid serial request of kind 0 (read) is refused and kinds 1 to 3 are allowed. While `secure` is low, every valid serial request is allowed.
- R8: `eraseDone` does not clear `secure`. It sets a sticky flag, `statusReg` bit 5, from the next cycle on. Only reset clears `secure` and that flag.
- R9: `statusReg` carries `preBoot` in bit 7, `secure` in bit 6 and the erase flag in bit 5. All other bits read 0.
- R10: The window counter saturates: `preBoot` stays low for any number of cycles until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Asynchronous active-low chip reset |
| regWrEn | input | 1 | Status register write strobe |
| regWrData | input | 8 | Status register write data |
| dbgReqValid | input | 1 | Debug port request present |
| dbgReqKind | input | 2 | Debug request kind: 0 read, 1 write, 2 page erase, 3 whole-array erase |
| spiReqValid | input | 1 | Serial port request present |
| spiReqKind | input | 2 | Serial request kind, same encoding |
| eraseDone | input | 1 | Whole-array erase completed (one-cycle pulse) |
| preBoot | output | 1 | Start-up window active |
| secure | output | 1 | Security latch |
| statusReg | output | 8 | Read-only status value |
| dbgAllow | output | 1 | Debug request granted |
| spiAllow | output | 1 | Serial request granted |

## Verification
The bound checker tests the following on every cycle:
- the window length, measured against its own cycle count since reset;
- that the window never reopens;
- that the latch never falls while reset is inactive, and rises only after a write with bit 6 set;
- the gating of both request ports;
- that the status bits agree with the discrete outputs.

Only the bench scenarios can show the remaining behaviour:
- arming after the window has closed still takes effect;
- an erase pulse without a reset leaves the latch set;
- a following reset releases it;
- writes of bit 7 have no visible effect.

// File: rtl/secure_pkg.sv
package secure_pkg;

  typedef enum logic [1:0] {
    REQ_READ       = 2'd0,
    REQ_WRITE      = 2'd1,
    REQ_PAGE_ERASE = 2'd2,
    REQ_BULK_ERASE = 2'd3
  } reqKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic countEn;
    logic setSecure;
    logic setWiped;
  } dpStrobe_t;

  localparam int STAT_PRE_BIT  = 7;
  localparam int STAT_SEC_BIT  = 6;
  localparam int STAT_WIPE_BIT = 5;

endpackage

// File: rtl/secDatapath.sv
module secDatapath
  import secure_pkg::*;
#(
  parameter int PREBOOT_CYCLES = 64,
  parameter int DATA_W         = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  output logic              preBoot,
  output logic              secure,
  output logic              wiped,
  output logic [DATA_W-1:0] statusReg
);

  localparam int CNT_W = $clog2(PREBOOT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PREBOOT_CYCLES);

  logic [CNT_W-1:0] cycleCnt;

  // Saturating window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt <= '0;
    end else if (strobe.countEn && (cycleCnt != LIMIT)) begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  assign preBoot = (cycleCnt != LIMIT);

  // Set-only latches, cleared by reset alone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secure <= 1'b0;
      wiped  <= 1'b0;
    end else begin
      if (strobe.setSecure) secure <= 1'b1;
      if (strobe.setWiped)  wiped  <= 1'b1;
    end
  end

  always_comb begin
    statusReg                = '0;
    statusReg[STAT_PRE_BIT]  = preBoot;
    statusReg[STAT_SEC_BIT]  = secure;
    statusReg[STAT_WIPE_BIT] = wiped;
  end

endmodule

// File: rtl/secControl.sv
module secControl
  import secure_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              preBoot,
  input  logic              secure,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              eraseDone,
  input  logic              dbgReqValid,
  input  logic [1:0]        dbgReqKind,
  input  logic              spiReqValid,
  input  logic [1:0]        spiReqKind,
  output dpStrobe_t         strobe,
  output logic              dbgAllow,
  output logic              spiAllow
);

  reqKind_e dbgKind;
  reqKind_e spiKind;

  assign dbgKind = reqKind_e'(dbgReqKind);
  assign spiKind = reqKind_e'(spiReqKind);

  always_comb begin
    strobe.countEn   = preBoot;
    strobe.setSecure = regWrEn && regWrData[STAT_SEC_BIT];
    strobe.setWiped  = eraseDone;
  end

  // Debug port: closed during the window, bulk erase only when secure
  always_comb begin
    dbgAllow = 1'b0;
    if (dbgReqValid && !preBoot) begin
      dbgAllow = !secure || (dbgKind == REQ_BULK_ERASE);
    end
  end

  // Serial port: reads refused when secure
  always_comb begin
    spiAllow = 1'b0;
    if (spiReqValid) begin
      spiAllow = !secure || (spiKind != REQ_READ);
    end
  end

endmodule

// File: rtl/bootSecurityCtl.sv
module bootSecurityCtl
  import secure_pkg::*;
#(
  parameter int PREBOOT_CYCLES = 64,
  parameter int DATA_W         = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              dbgReqValid,
  input  logic [1:0]        dbgReqKind,
  input  logic              spiReqValid,
  input  logic [1:0]        spiReqKind,
  input  logic              eraseDone,
  output logic              preBoot,
  output logic              secure,
  output logic [DATA_W-1:0] statusReg,
  output logic              dbgAllow,
  output logic              spiAllow
);

  dpStrobe_t strobe;
  logic      wiped;

  secControl #(.DATA_W(DATA_W)) u_ctl (
    .preBoot     (preBoot),
    .secure      (secure),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .eraseDone   (eraseDone),
    .dbgReqValid (dbgReqValid),
    .dbgReqKind  (dbgReqKind),
    .spiReqValid (spiReqValid),
    .spiReqKind  (spiReqKind),
    .strobe      (strobe),
    .dbgAllow    (dbgAllow),
    .spiAllow    (spiAllow)
  );

  secDatapath #(.PREBOOT_CYCLES(PREBOOT_CYCLES), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .preBoot   (preBoot),
    .secure    (secure),
    .wiped     (wiped),
    .statusReg (statusReg)
  );

endmodule

// File: rtl/secCheck.sv
module secCheck #(
  parameter int PREBOOT_CYCLES = 64,
  parameter int DATA_W         = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic              dbgReqValid,
  input logic [1:0]        dbgReqKind,
  input logic              spiReqValid,
  input logic [1:0]        spiReqKind,
  input logic              eraseDone,
  input logic              preBoot,
  input logic              secure,
  input logic [DATA_W-1:0] statusReg,
  input logic              dbgAllow,
  input logic              spiAllow
);

  int unsigned sinceReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceReset <= 0;
    else if (sinceReset < PREBOOT_CYCLES) sinceReset <= sinceReset + 1;
  end

  // R1
  window_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    preBoot == (sinceReset < PREBOOT_CYCLES));

  // R10
  window_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    !preBoot |=> !preBoot);

  // R2
  dbg_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    preBoot |-> !dbgAllow);

  // R3
  dbg_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!preBoot && !secure) |-> (dbgAllow == dbgReqValid));

  // R5
  secure_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    secure |=> secure);

  // R4
  secure_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(secure) |-> $past(regWrEn && regWrData[6]));

  // R6
  dbg_secure_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secure && dbgAllow) |-> (dbgReqKind == 2'd3));

  // R7
  spi_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secure && spiReqKind == 2'd0) |-> !spiAllow);

  // R9
  status_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg[7] == preBoot) && (statusReg[6] == secure) && (statusReg[4:0] == '0));

endmodule

bind bootSecurityCtl secCheck #(
  .PREBOOT_CYCLES(PREBOOT_CYCLES),
  .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/bootSecurityCtl_tb.sv
`timescale 1ns/1ps
module bootSecurityCtl_tb;

  localparam int WIN = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic       dbgReqValid = 1'b0;
  logic [1:0] dbgReqKind = '0;
  logic       spiReqValid = 1'b0;
  logic [1:0] spiReqKind = '0;
  logic       eraseDone = 1'b0;
  logic       preBoot, secure, dbgAllow, spiAllow;
  logic [7:0] statusReg;

  int checks = 0;
  int errors = 0;
  bit cmpOn = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bootSecurityCtl u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .dbgReqValid(dbgReqValid), .dbgReqKind(dbgReqKind),
    .spiReqValid(spiReqValid), .spiReqKind(spiReqKind),
    .eraseDone(eraseDone), .preBoot(preBoot), .secure(secure),
    .statusReg(statusReg), .dbgAllow(dbgAllow), .spiAllow(spiAllow)
  );

  // Behavioural reference state
  int mCycles = 0;
  bit mSecure = 1'b0;
  bit mWiped  = 1'b0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCycles = 0; mSecure = 1'b0; mWiped = 1'b0;
    end else begin
      if (mCycles < WIN) mCycles = mCycles + 1;
      if (regWrEn && regWrData[6]) mSecure = 1'b1;
      if (eraseDone) mWiped = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (cmpOn && !finished) begin
      bit   ePre, eDbg, eSpi;
      logic [7:0] eStat;
      ePre  = (mCycles < WIN);
      eDbg  = dbgReqValid && !ePre && (!mSecure || dbgReqKind == 2'd3);
      eSpi  = spiReqValid && (!mSecure || spiReqKind != 2'd0);
      eStat = {ePre, mSecure, mWiped, 5'b0};
      check(preBoot == ePre, "R1", preBoot, ePre);
      check(secure == mSecure, "R4", secure, mSecure);
      check(dbgAllow == eDbg, ePre ? "R2" : (mSecure ? "R6" : "R3"), dbgAllow, eDbg);
      check(spiAllow == eSpi, "R7", spiAllow, eSpi);
      check(statusReg == eStat, "R9", statusReg, eStat);
    end
  end

  task automatic drive(input bit wr, input logic [7:0] d, input bit dv, input logic [1:0] dk,
                       input bit sv, input logic [1:0] sk, input bit er);
    @(negedge clk);
    regWrEn = wr; regWrData = d; dbgReqValid = dv; dbgReqKind = dk;
    spiReqValid = sv; spiReqKind = sk; eraseDone = er;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 8'h00, 0, 2'd0, 0, 2'd0, 0);
  endtask

  task automatic sweep();
    for (int k = 0; k < 4; k++) drive(0, 8'h00, 1, 2'(k), 1, 2'(3 - k), 0);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    idle(3);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic probe(); @(negedge clk); #2; endtask

  initial begin
    idle(3);
    @(negedge clk); rstN = 1'b1; cmpOn = 1'b1;
    #2;
    check(preBoot === 1'b1 && secure === 1'b0 && statusReg === 8'h80, "R9", statusReg, 8'h80);
    // Requests during the window
    for (int j = 0; j < 8; j++) sweep();
    idle(WIN);
    probe(); check(preBoot == 1'b0, "R1", preBoot, 0);
    sweep();
    // R5: bit 7 write ignored
    drive(1, 8'h80, 0, 2'd0, 0, 2'd0, 0); idle(1);
    probe(); check(statusReg[7] == 1'b0 && secure == 1'b0, "R5", statusReg, 8'h00);
    // R4: arm after window closes
    drive(1, 8'h40, 0, 2'd0, 0, 2'd0, 0); idle(1);
    probe(); check(secure == 1'b1, "R4", secure, 1);
    drive(1, 8'h00, 0, 2'd0, 0, 2'd0, 0); drive(1, 8'hBF, 0, 2'd0, 0, 2'd0, 0); idle(1);
    probe(); check(secure == 1'b1, "R5", secure, 1);
    sweep(); sweep();
    // R8: erase without reset keeps secure
    drive(0, 8'h00, 0, 2'd0, 0, 2'd0, 1); idle(2);
    probe(); check(secure == 1'b1 && statusReg[5] == 1'b1, "R8", statusReg, 8'h60);
    sweep();
    doReset();
    #2; check(secure == 1'b0 && statusReg == 8'h80, "R8", statusReg, 8'h80);
    // Arm inside the window
    idle(4);
    drive(1, 8'hC0, 1, 2'd3, 1, 2'd0, 0);
    for (int j = 0; j < 4; j++) sweep();
    probe(); check(secure == 1'b1 && preBoot == 1'b1 && dbgAllow == 1'b0, "R2", dbgAllow, 0);
    idle(WIN);
    sweep(); sweep();
    idle(300);
    probe(); check(preBoot == 1'b0, "R10", preBoot, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule